// File: doc/BRIEF.md
# Multi-Rail Reset Supervisor Sequencer

This block turns the verdicts of three supply comparators and a push-button into one system reset. The comparator results reach it as asynchronous digital flags. A low-supply flag covers the primary rail, a second low-supply flag covers an auxiliary rail, and a level flag covers a third rail. The third flag reports whether the rail sits above its threshold. A parameter decides whether "below" (undervoltage watch) or "above" (overvoltage watch) counts as the fault side. The push-button is active-low and is debounced inside the block.

Every fault source feeds one release timer. Any fault asserts reset at once and clears the timer. Reset is released only after all sources have stayed clean for one full, uninterrupted timeout. The timeout is built from a prescaler that produces a tick every `TICK_DIV` clocks and a counter that waits for `TIMEOUT_TICKS` ticks, so raising `TICK_DIV` stretches it. The block drives an active-low reset and an active-high reset, both decoded from one state register. All pins are plain level signals. No data stream crosses the block, so it has no valid/ready handshake and no back-pressure.

Top module: `rsup_supervisor`

## Requirements
- R1: After `rst_n` is released, both reset outputs stay asserted until the inputs have been compliant for the full timeout. With compliant inputs already present at release, the outputs deassert exactly `TIMEOUT_TICKS*TICK_DIV+4` clocks later.
- R2: A high `main_low_i` (primary rail below threshold) asserts reset on the 3rd clock edge after the change. This latency stays far inside the 10 µs bound.
- R3: A high `aux_low_i` (second rail below threshold) asserts reset with the same 3-edge latency.
- R4: With `THIRD_OV=0`, a low `third_above_i` is a fault and asserts reset with the same latency. A high level has no effect.
- R5: With `THIRD_OV=1`, a high `third_above_i` is a fault and asserts reset with the same latency. A low level has no effect.
- R6: The timeout lasts `TIMEOUT_TICKS*TICK_DIV` clocks. After the last fault input returns to compliance, reset deasserts on the `TIMEOUT_TICKS*TICK_DIV+4`-th edge. The defaults (`TICK_DIV`=50000, `TIMEOUT_TICKS`=200) give 10,000,000 clocks, which is 200 ms at 50 MHz and above the 140 ms minimum.
- R7: A fault that appears while the timeout is counting keeps reset asserted and clears the count. The full timeout then restarts once that fault clears.
- R8: A low `btn_n_i` held for at least `DEB_CYC` consecutive synchronized samples asserts reset. It does so on edge `DEB_CYC+3` after the press. The default of 50 cycles is 1 µs at 50 MHz.
- R9: A low pulse on `btn_n_i` that is shorter than `DEB_CYC` clocks never asserts reset.
- R10: After the button is released, reset stays asserted for one full timeout. It deasserts on edge `TIMEOUT_TICKS*TICK_DIV+5` after the release.
- R11: `sys_rst_o` is always the complement of `sys_rst_n_o`, and both change in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| main_low_i | input | 1 | Primary rail below threshold (asynchronous) |
| aux_low_i | input | 1 | Second rail below threshold (asynchronous) |
| third_above_i | input | 1 | Third rail above threshold (asynchronous) |
| btn_n_i | input | 1 | Active-low push-button (asynchronous) |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
Each input change is applied at a falling edge. The latency to the output then follows from the register chain: two synchronizer flops and the state flop give assertion at edge 3 for a rail fault. The debouncer adds `DEB_CYC` edges for the button. Release takes the timeout plus four edges, or plus five for the button, because of the extra debounce register. For each change, the bench schedules a check of the old level one cycle before the due edge and a check of the new level at the due edge. A result that arrives early or late is therefore caught. While the timer counts, extra checks at the cycle where an uncleared count would have finished show that a mid-count fault restarted the period.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } sup_state_e;

  // bit positions inside the synchronized flag vector
  localparam int unsigned IDX_MAIN  = 0;
  localparam int unsigned IDX_AUX   = 1;
  localparam int unsigned IDX_THIRD = 2;
  localparam int unsigned IDX_BTN   = 3;
  localparam int unsigned NFLAGS    = 4;
endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rsup_debounce.sv
module rsup_debounce #(
  parameter int unsigned HOLD_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_low_i,
  output logic held_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!btn_low_i)       cnt_q <= '0;
    else if (cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
  end

  assign held_o = (cnt_q == LIMIT);

  // R9
  held_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_o |-> $past(btn_low_i));
endmodule

// File: rtl/rsup_timer.sv
module rsup_timer #(
  parameter int unsigned TICK_DIV = 50000,
  parameter int unsigned TICKS    = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned TW = $clog2(TICKS + 1);
  localparam logic [TW-1:0] TLIM = TW'(TICKS);

  logic          tick;
  logic [TW-1:0] ticks_q;

  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam int unsigned PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] PLIM = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pre_q <= '0;
        else if (!run_i)         pre_q <= '0;
        else if (pre_q == PLIM)  pre_q <= '0;
        else                     pre_q <= pre_q + 1'b1;
      end
      assign tick = run_i && (pre_q == PLIM);
    end else begin : g_nopre
      assign tick = run_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ticks_q <= '0;
    else if (!run_i)            ticks_q <= '0;
    else if (tick && !done_o)   ticks_q <= ticks_q + 1'b1;
  end

  assign done_o = (ticks_q == TLIM);

  // R6
  ticks_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ticks_q <= TLIM);
  // R7
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (ticks_q == '0));
endmodule

// File: rtl/rsup_supervisor.sv
module rsup_supervisor
  import rsup_pkg::*;
#(
  parameter bit          THIRD_OV      = 1'b0,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned DEB_CYC       = 50,
  parameter int unsigned TICK_DIV      = 50000,
  parameter int unsigned TIMEOUT_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_low_i,
  input  logic aux_low_i,
  input  logic third_above_i,
  input  logic btn_n_i,
  output logic sys_rst_n_o,
  output logic sys_rst_o
);
  // synchronizers start on the fault side (button released)
  localparam logic [NFLAGS-1:0] SYNC_INIT = {1'b1, THIRD_OV, 1'b1, 1'b1};

  logic [NFLAGS-1:0] raw, syn;
  logic third_bad, btn_held, fault, run, done;
  sup_state_e state_q, state_d;

  assign raw[IDX_MAIN]  = main_low_i;
  assign raw[IDX_AUX]   = aux_low_i;
  assign raw[IDX_THIRD] = third_above_i;
  assign raw[IDX_BTN]   = btn_n_i;

  rsup_sync #(.W(NFLAGS), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_INIT)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

  rsup_debounce #(.HOLD_CYC(DEB_CYC)) u_deb (
    .clk(clk), .rst_n(rst_n), .btn_low_i(~syn[IDX_BTN]), .held_o(btn_held));

  generate
    if (THIRD_OV) begin : g_ov
      assign third_bad = syn[IDX_THIRD];
    end else begin : g_uv
      assign third_bad = ~syn[IDX_THIRD];
    end
  endgenerate

  assign fault = syn[IDX_MAIN] | syn[IDX_AUX] | third_bad | btn_held;
  assign run   = (state_q == ST_COUNT) && !fault;

  rsup_timer #(.TICK_DIV(TICK_DIV), .TICKS(TIMEOUT_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(run), .done_o(done));

  always_comb begin
    state_d = state_q;
    if (fault) state_d = ST_HOLD;
    else begin
      unique case (state_q)
        ST_HOLD:  state_d = ST_COUNT;
        ST_COUNT: if (done) state_d = ST_RUN;
        ST_RUN:   state_d = ST_RUN;
        default:  state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HOLD;
    else        state_q <= state_d;
  end

  assign sys_rst_o   = (state_q != ST_RUN);
  assign sys_rst_n_o = (state_q == ST_RUN);

  // R2
  fault_reacts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> sys_rst_o);
  // R6
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> $past(done));
  // R1
  assert_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(fault));
  // R7
  count_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && fault) |=> (state_q == ST_HOLD));
endmodule

// File: tb/tb_rsup_supervisor.sv
module tb_rsup_supervisor;
  localparam int unsigned DIV = 4;
  localparam int unsigned TT  = 5;
  localparam int unsigned DEB = 4;
  localparam int TD = DIV * TT;

  typedef struct {
    int    due;
    bit    ov;
    bit    exp;
    string tag;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_low = 1'b0, aux_low = 1'b0, btn_n = 1'b1;
  logic third_uv = 1'b1, third_ov = 1'b0;
  logic uv_rst_n, uv_rst, ov_rst_n, ov_rst;
  int cyc = 0;
  int tests = 0;
  int fails = 0;
  ev_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rsup_supervisor #(.THIRD_OV(1'b0), .SYNC_STAGES(2), .DEB_CYC(DEB),
    .TICK_DIV(DIV), .TIMEOUT_TICKS(TT)) dut (
    .clk(clk), .rst_n(rst_n), .main_low_i(main_low), .aux_low_i(aux_low),
    .third_above_i(third_uv), .btn_n_i(btn_n),
    .sys_rst_n_o(uv_rst_n), .sys_rst_o(uv_rst));

  rsup_supervisor #(.THIRD_OV(1'b1), .SYNC_STAGES(2), .DEB_CYC(DEB),
    .TICK_DIV(DIV), .TIMEOUT_TICKS(TT)) dut_ov (
    .clk(clk), .rst_n(rst_n), .main_low_i(main_low), .aux_low_i(aux_low),
    .third_above_i(third_ov), .btn_n_i(btn_n),
    .sys_rst_n_o(ov_rst_n), .sys_rst_o(ov_rst));

  task automatic expect_at(input int due, input bit ov, input bit exp, input string tag);
    ev_t e;
    e.due = due; e.ov = ov; e.exp = exp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expect_both(input int due, input bit exp, input string tag);
    expect_at(due, 1'b0, exp, tag);
    expect_at(due, 1'b1, exp, tag);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: compares scheduled expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      ev_t e;
      logic a, an;
      e = q.pop_front();
      a  = e.ov ? ov_rst   : uv_rst;
      an = e.ov ? ov_rst_n : uv_rst_n;
      tests++;
      if (e.due != cyc || a !== e.exp) begin
        fails++;
        $display("FAIL %s (%s) cycle %0d: actual=%b expected=%b", e.tag,
                 e.ov ? "ov" : "uv", cyc, a, e.exp);
      end
      tests++;
      if (an !== ~a) begin
        fails++;
        $display("FAIL R11 (%s) cycle %0d: actual n=%b expected n=%b",
                 e.ov ? "ov" : "uv", cyc, an, ~a);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : driver
    int c;
    repeat (3) @(negedge clk);
    // R1 reset state
    tests++;
    if (uv_rst !== 1'b1 || ov_rst !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset state: actual=%b%b expected=11", uv_rst, ov_rst);
    end
    // R1 power-up release
    c = cyc; rst_n = 1'b1;
    expect_both(c + 3 + TD, 1'b1, "R1");
    expect_both(c + 4 + TD, 1'b0, "R1");
    drain();

    // R2 primary rail
    c = cyc; main_low = 1'b1;
    expect_both(c + 2, 1'b0, "R2"); expect_both(c + 3, 1'b1, "R2");
    drain();
    c = cyc; main_low = 1'b0;
    expect_both(c + 3 + TD, 1'b1, "R6"); expect_both(c + 4 + TD, 1'b0, "R6");
    drain();

    // R3 second rail
    c = cyc; aux_low = 1'b1;
    expect_both(c + 2, 1'b0, "R3"); expect_both(c + 3, 1'b1, "R3");
    drain();
    c = cyc; aux_low = 1'b0;
    expect_both(c + 3 + TD, 1'b1, "R6"); expect_both(c + 4 + TD, 1'b0, "R6");
    drain();

    // R4 undervoltage sense on third rail; overvoltage instance unaffected
    c = cyc; third_uv = 1'b0;
    expect_at(c + 2, 1'b0, 1'b0, "R4"); expect_at(c + 3, 1'b0, 1'b1, "R4");
    expect_at(c + 3, 1'b1, 1'b0, "R5");
    drain();
    c = cyc; third_uv = 1'b1;
    expect_at(c + 4 + TD, 1'b0, 1'b0, "R4");
    drain();

    // R5 overvoltage sense; undervoltage instance ignores a high level
    c = cyc; third_ov = 1'b1;
    expect_at(c + 2, 1'b1, 1'b0, "R5"); expect_at(c + 3, 1'b1, 1'b1, "R5");
    expect_at(c + 3, 1'b0, 1'b0, "R4");
    drain();
    c = cyc; third_ov = 1'b0;
    expect_at(c + 3 + TD, 1'b1, 1'b1, "R5"); expect_at(c + 4 + TD, 1'b1, 1'b0, "R5");
    drain();

    // R7 fault during count restarts the full period
    c = cyc; main_low = 1'b1;
    expect_both(c + 3, 1'b1, "R7");
    drain();
    c = cyc; main_low = 1'b0;
    expect_both(c + 4 + TD, 1'b1, "R7");
    repeat (10) @(negedge clk);
    main_low = 1'b1;
    repeat (4) @(negedge clk);
    c = cyc; main_low = 1'b0;
    expect_both(c + 3 + TD, 1'b1, "R7"); expect_both(c + 4 + TD, 1'b0, "R7");
    drain();

    // R8 debounced button press, R10 release timing
    c = cyc; btn_n = 1'b0;
    expect_both(c + 2 + DEB, 1'b0, "R8"); expect_both(c + 3 + DEB, 1'b1, "R8");
    drain();
    c = cyc; btn_n = 1'b1;
    expect_both(c + 4 + TD, 1'b1, "R10"); expect_both(c + 5 + TD, 1'b0, "R10");
    drain();

    // R9 pulse one cycle short of the debounce window
    c = cyc; btn_n = 1'b0;
    for (int i = 1; i <= DEB + 8; i++) expect_both(c + i, 1'b0, "R9");
    repeat (DEB - 1) @(negedge clk);
    btn_n = 1'b1;
    drain();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule